// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Transmit Buffer

This block is the transmit store for one bulk IN endpoint. It holds two packet layers of up to 64 bytes each and uses them in ping-pong order, so firmware on the local microcontroller can fill one layer while the other waits for, or is being sent to, the host. Firmware pushes bytes through a valid/ready write stream and then pulses `commit` to hand the filled layer to the USB side. The write side then moves to the other layer.

The USB side works on the oldest committed layer. An `in_token` pulse starts sending that layer. Its bytes leave on a valid/ready transmit stream, together with the byte count captured at commit time. A `host_ack` pulse frees the layer and moves the read side to the other layer. A `host_noack` pulse, which covers a timeout or a rejected handshake, keeps the layer and rewinds it so the next token sends the same packet again.

Back-pressure works as follows. On the write stream, a byte transfers in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the current write layer is committed, while it already holds 64 bytes, and in any cycle where `commit` is high. On the transmit stream, a byte transfers in a cycle where `tx_valid` and `tx_ready` are both high. While the sink stalls, `tx_data` and `tx_last` do not change.

The status bit `pkt_rdy` and the interrupt `irq` tell firmware whether any layer is free. They do not report whether a particular layer is full.

Top module: `usb_in_pingpong`

## Requirements
- R1: A synchronous reset has the following effects:
  - Both layers become empty.
  - The write side and the read side both select layer A.
  - `tx_busy` and `pkt_rdy` go to 0.
  - `wr_ready` goes to 1 and `irq` follows `irq_en`.
- R2: The write stream accepts a byte on `wr_valid && wr_ready`. `wr_ready` is 0 in each of these cases:
  - The current write layer is committed.
  - The current write layer holds 64 bytes.
  - `commit` is high in that cycle.
- R3: A `commit` pulse while the write layer is not committed does three things:
  - It marks that layer ready.
  - It records the number of bytes written to it.
  - It moves later writes to the other layer.

  A `commit` while the write layer is already committed is ignored.
- R4: `pkt_rdy` is 1 exactly when both layers are committed. It reads 0 while either layer is empty.
- R5: `irq` equals `irq_en` AND (at least one layer empty).
- R6: An `in_token` pulse while no packet is being sent and the read layer is committed starts sending, and `tx_busy` rises in the next cycle. During sending:
  - `tx_len` gives the recorded count.
  - Bytes come out in the order they were written.
  - `tx_last` marks the final byte.

  An `in_token` pulse while no packet is being sent and the read layer is empty raises `tx_nak` in that same cycle and changes no state.
- R7: `host_ack` while sending frees the layer being sent and ends sending. Layers are sent in strict alternation: A, B, A, and so on.
- R8: `host_noack` while sending ends sending but keeps the layer committed. The next `in_token` sends the same packet again from its first byte.
- R9: A layer committed with no bytes is sent with `tx_len` 0 and `tx_valid` never high.
- R10: If the layer being sent is freed before the other layer is committed, firmware can commit the other layer and then write the freed layer at once.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value until the byte transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_en | input | 1 | Interrupt enable |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write layer can take a byte |
| wr_data | input | 8 | Write byte |
| commit | input | 1 | Packet-ready pulse for the current write layer |
| in_token | input | 1 | IN token received pulse |
| tx_nak | output | 1 | Token arrived with nothing committed |
| tx_busy | output | 1 | A layer is being sent |
| tx_len | output | 7 | Byte count of the read layer |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Serial engine takes the byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| host_ack | input | 1 | Host acknowledged the sent packet |
| host_noack | input | 1 | No acknowledge; resend later |
| pkt_rdy | output | 1 | Both layers committed |
| irq | output | 1 | Firmware may write a packet |

## Verification
The bench covers the following cases, and what a faulty design would do in each:
- **Rejected handshake:** the bench sends a packet, answers it with no acknowledge, then drains it again. A design that forgot to rewind would send a truncated packet. A design that advanced the layer would send the other packet.
- **Redundant commit:** the bench pulses `commit` while both layers are full, then frees one layer. A design that toggled the write side on that commit would leave `wr_ready` low.
- **Full buffer:** the bench fills a layer to 64 bytes and checks that `wr_ready` drops.
- **Zero-length packet:** the bench checks that such a packet produces a count of 0 and no data beats.
- **Stalled sink:** the bench throttles `tx_ready` to catch data that changes while the sink stalls.
- **Early free:** the bench frees the sent layer before the other layer is committed. A design that tied the interrupt to a single FIFO would leave the interrupt wrong here.

// File: rtl/usb_pp_pkg.sv
package usb_pp_pkg;
  typedef enum logic {LYR_A = 1'b0, LYR_B = 1'b1} lyr_e;

  function automatic lyr_e lyr_next(lyr_e l);
    return (l == LYR_A) ? LYR_B : LYR_A;
  endfunction
endpackage

// File: rtl/pp_layer_ram.sv
module pp_layer_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import usb_pp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          commit,
  input  logic          in_token,
  input  logic          host_ack,
  input  logic          host_noack,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic          tx_last,
  output logic          tx_busy,
  output logic          tx_nak,
  output logic [CW-1:0] tx_len,
  output logic          both_full,
  output lyr_e          wsel,
  output lyr_e          rsel,
  output logic [CW-1:0] wr_ptr,
  output logic [CW-1:0] rd_ptr
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [1:0]         lyr_full;
  logic [1:0][CW-1:0] lyr_len;
  logic               tx_act;
  logic               wr_fire, tx_fire, start, do_commit;

  assign wr_ready  = !lyr_full[wsel] && (wr_ptr < CAP) && !commit;
  assign wr_fire   = wr_valid && wr_ready;
  assign do_commit = commit && !lyr_full[wsel];
  assign tx_len    = lyr_len[rsel];
  assign tx_valid  = tx_act && (rd_ptr < lyr_len[rsel]);
  assign tx_last   = tx_valid && (rd_ptr == lyr_len[rsel] - 1'b1);
  assign tx_fire   = tx_valid && tx_ready;
  assign start     = in_token && !tx_act && lyr_full[rsel];
  assign tx_nak    = in_token && !tx_act && !lyr_full[rsel];
  assign tx_busy   = tx_act;
  assign both_full = &lyr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      lyr_full <= '0;
      lyr_len  <= '0;
      wsel     <= LYR_A;
      rsel     <= LYR_A;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      tx_act   <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (do_commit) begin
        lyr_full[wsel] <= 1'b1;
        lyr_len[wsel]  <= wr_ptr;
        wr_ptr         <= '0;
        wsel           <= lyr_next(wsel);
      end
      if (tx_fire) rd_ptr <= rd_ptr + 1'b1;
      if (start) begin
        tx_act <= 1'b1;
        rd_ptr <= '0;
      end
      if (tx_act && host_ack) begin
        lyr_full[rsel] <= 1'b0;
        rsel           <= lyr_next(rsel);
        tx_act         <= 1'b0;
        rd_ptr         <= '0;
      end else if (tx_act && host_noack) begin
        tx_act <= 1'b0;
        rd_ptr <= '0;
      end
    end
  end

  // R3
  commit_flip_chk: assert property (@(posedge clk) disable iff (rst)
    do_commit |=> (lyr_full[$past(wsel)] && wsel != $past(wsel)));

  // R7
  ack_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_act && host_ack) |=> (rsel != $past(rsel) && !tx_act));

  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_act && host_noack && !host_ack) |=> (rd_ptr == '0 && rsel == $past(rsel)));

  // R6
  rd_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tx_act |-> (rd_ptr <= lyr_len[rsel]));
endmodule

// File: rtl/usb_in_pingpong.sv
module usb_in_pingpong
  import usb_pp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          in_token,
  output logic          tx_nak,
  output logic          tx_busy,
  output logic [CW-1:0] tx_len,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic          host_ack,
  input  logic          host_noack,
  output logic          pkt_rdy,
  output logic          irq
);
  lyr_e          wsel, rsel;
  logic [CW-1:0] wr_ptr, rd_ptr;
  logic          both_full;
  logic [DW-1:0] rdata [2];

  pp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .commit(commit), .in_token(in_token), .host_ack(host_ack),
    .host_noack(host_noack), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_busy(tx_busy), .tx_nak(tx_nak), .tx_len(tx_len),
    .both_full(both_full), .wsel(wsel), .rsel(rsel),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  for (genvar g = 0; g < 2; g++) begin : g_layer
    pp_layer_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
      .clk(clk),
      .we(wr_valid && wr_ready && (wsel == lyr_e'(g))),
      .waddr(wr_ptr[AW-1:0]),
      .wdata(wr_data),
      .raddr(rd_ptr[AW-1:0]),
      .rdata(rdata[g])
    );
  end

  assign tx_data = rdata[rsel];
  assign pkt_rdy = both_full;
  assign irq     = irq_en && !both_full;

  // R5
  irq_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en && !irq) |-> !wr_ready);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !host_ack && !host_noack && !rst)
      |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/sim_usb_in_pingpong.sv
module sim_usb_in_pingpong;
  localparam int CLK_P = 10;

  localparam logic [2:0] OP_WR = 3'd0, OP_CM = 3'd1, OP_TK = 3'd2,
                         OP_DR = 3'd3, OP_AK = 3'd4, OP_NK = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic       rdy;
    logic       irq;
    logic       busy;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{OP_WR, 8'd5,  1'b0, 1'b1, 1'b0},
    '{OP_CM, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_WR, 8'd64, 1'b0, 1'b1, 1'b0},
    '{OP_CM, 8'd0,  1'b1, 1'b0, 1'b0},
    '{OP_TK, 8'd0,  1'b1, 1'b0, 1'b1},
    '{OP_DR, 8'd0,  1'b1, 1'b0, 1'b1},
    '{OP_NK, 8'd0,  1'b1, 1'b0, 1'b0},
    '{OP_TK, 8'd0,  1'b1, 1'b0, 1'b1},
    '{OP_DR, 8'd0,  1'b1, 1'b0, 1'b1},
    '{OP_AK, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_TK, 8'd0,  1'b0, 1'b1, 1'b1},
    '{OP_DR, 8'd1,  1'b0, 1'b1, 1'b1},
    '{OP_AK, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_CM, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_TK, 8'd0,  1'b0, 1'b1, 1'b1},
    '{OP_DR, 8'd2,  1'b0, 1'b1, 1'b1},
    '{OP_AK, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_WR, 8'd3,  1'b0, 1'b1, 1'b0},
    '{OP_CM, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_TK, 8'd0,  1'b0, 1'b1, 1'b1},
    '{OP_WR, 8'd7,  1'b0, 1'b1, 1'b1},
    '{OP_DR, 8'd3,  1'b0, 1'b1, 1'b1},
    '{OP_AK, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_CM, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_WR, 8'd2,  1'b0, 1'b1, 1'b0},
    '{OP_CM, 8'd0,  1'b1, 1'b0, 1'b0},
    '{OP_TK, 8'd0,  1'b1, 1'b0, 1'b1},
    '{OP_DR, 8'd4,  1'b1, 1'b0, 1'b1},
    '{OP_AK, 8'd0,  1'b0, 1'b1, 1'b0},
    '{OP_TK, 8'd0,  1'b0, 1'b1, 1'b1},
    '{OP_DR, 8'd5,  1'b0, 1'b1, 1'b1},
    '{OP_AK, 8'd0,  1'b0, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_en = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       commit = 1'b0, in_token = 1'b0, tx_ready = 1'b0;
  logic       host_ack = 1'b0, host_noack = 1'b0;
  logic       wr_ready, tx_nak, tx_busy, tx_valid, tx_last, pkt_rdy, irq;
  logic [6:0] tx_len;
  logic [7:0] tx_data;

  int n_cmp = 0, n_bad = 0;
  int wk = 0, wcount = 0;
  int lens [16];

  always #(CLK_P/2) clk = ~clk;

  usb_in_pingpong u0 (
    .clk(clk), .rst(rst), .irq_en(irq_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .commit(commit),
    .in_token(in_token), .tx_nak(tx_nak), .tx_busy(tx_busy),
    .tx_len(tx_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .host_ack(host_ack),
    .host_noack(host_noack), .pkt_rdy(pkt_rdy), .irq(irq)
  );

  function automatic logic [7:0] pat(int k, int i);
    return 8'(k * 37 + i * 3 + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_data  = pat(wk, wcount);
      #1;
      chk("R2 ready while filling", wr_ready, 1);
      tick();
      wcount++;
    end
    wr_valid = 1'b0;
  endtask

  task automatic do_commit();
    commit = 1'b1;
    tick();
    commit = 1'b0;
    lens[wk] = wcount;
    wk++;
    wcount = 0;
  endtask

  task automatic pulse_token();
    in_token = 1'b1;
    tick();
    in_token = 1'b0;
  endtask

  task automatic pulse_ack(bit ok);
    if (ok) host_ack = 1'b1; else host_noack = 1'b1;
    tick();
    host_ack = 1'b0;
    host_noack = 1'b0;
  endtask

  task automatic drain(int id);
    int len;
    int idx;
    logic hv;
    logic [7:0] held;
    len = lens[id];
    idx = 0;
    hv = 1'b0;
    held = '0;
    chk("R6/R9 packet length", 32'(tx_len), len);
    for (int c = 0; c < 400 && idx < len; c++) begin
      tx_ready = c[0];
      #1;
      if (hv) chk("R11 data held under stall", tx_data, held);
      if (!tx_valid) chk("R6 valid during packet", tx_valid, 1);
      else begin
        chk("R6 byte order", tx_data, pat(id, idx));
        chk("R6 last marker", tx_last, (idx == len - 1));
      end
      hv = tx_valid && !tx_ready;
      held = tx_data;
      if (tx_valid && tx_ready) idx++;
      tick();
    end
    tx_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      tx_ready = 1'b1;
      #1;
      chk("R9 no beat past count", tx_valid, 0);
      tick();
    end
    tx_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 pkt_rdy after reset", pkt_rdy, 0);
    chk("R1 irq after reset", irq, 1);
    chk("R1 busy after reset", tx_busy, 0);
    chk("R1 wr_ready after reset", wr_ready, 1);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v].op)
        OP_WR: do_write(int'(VEC[v].arg));
        OP_CM: do_commit();
        OP_TK: pulse_token();
        OP_DR: drain(int'(VEC[v].arg));
        OP_AK: pulse_ack(1'b1);
        OP_NK: pulse_ack(1'b0);
        default: ;
      endcase
      chk("R4 pkt_rdy vector", pkt_rdy, VEC[v].rdy);
      chk("R5/R10 irq vector", irq, VEC[v].irq);
      chk("R7/R8 busy vector", tx_busy, VEC[v].busy);
    end

    // R6 token with nothing committed -> nak, no start
    in_token = 1'b1;
    #1;
    chk("R6 nak on empty", tx_nak, 1);
    tick();
    in_token = 1'b0;
    chk("R6 no start on empty", tx_busy, 0);

    // R2 full layer blocks writes
    do_write(64);
    #1;
    chk("R2 ready low at 64 bytes", wr_ready, 0);
    do_commit();
    // R2 commit cycle blocks writes
    wr_valid = 1'b1;
    commit = 1'b1;
    #1;
    chk("R2 ready low during commit", wr_ready, 0);
    tick();
    wr_valid = 1'b0;
    commit = 1'b0;
    chk("R4 both committed", pkt_rdy, 1);

    // R3 commit with write layer committed is ignored
    commit = 1'b1;
    tick();
    commit = 1'b0;
    pulse_token();
    pulse_ack(1'b1);
    #1;
    chk("R3 ignored commit keeps write layer", wr_ready, 1);
    chk("R4 one layer free", pkt_rdy, 0);

    // R5 interrupt enable gating
    irq_en = 1'b0;
    #1;
    chk("R5 irq masked", irq, 0);
    irq_en = 1'b1;
    #1;
    chk("R5 irq unmasked", irq, 1);

    // R1 reset mid-operation
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 pkt_rdy after mid reset", pkt_rdy, 0);
    chk("R1 busy after mid reset", tx_busy, 0);
    chk("R1 wr_ready after mid reset", wr_ready, 1);
    in_token = 1'b1;
    #1;
    chk("R1 layers cleared by reset", tx_nak, 1);
    tick();
    in_token = 1'b0;

    finish_run();
  end
endmodule